// File: doc/BRIEF.md
# Branch-Checkpointed Speculative Register File

This block holds several complete copies of the architectural register set, one copy per level of unresolved branch speculation. The copies are arranged as a ring of rows. The oldest busy row is the committed state. The youngest busy row is the active working copy, and all reads and writes go to it.

Entering a predicted branch claims the next row of the ring. That row is loaded in one cycle with the whole contents of the active row. If the prediction turns out wrong, the row tied to that branch is thrown away, and so is every row opened after it; the row just before it becomes active again. If the prediction is correct, the row is marked confirmed. A retire request then releases the oldest row, provided the row after it is confirmed. Scheduling, renaming and prediction are handled outside this block.

Top module: `spec_ckpt_regfile`

## Requirements
- R1: After reset exactly one row (row 0) is busy and every register reads 0. `br_full` is 0, and `br_tag` shows 1, the row the next branch would claim.
- R2: A write with `wr_en`=1 lands in the youngest busy row at the clock edge. `rd_data` shows, without a clock, the register `rd_addr` of the youngest busy row.
- R3: An accepted `br_enter` makes the row shown on `br_tag` the youngest row. That row receives a copy of every register of the previous youngest row, including a write made in the same cycle. Later writes change only the new row.
- R4: When all `NROW` rows are busy, `br_full` is 1, a `br_enter` is refused, and `br_tag` does not change.
- R5: A resolve with `res_ok`=0 on a busy branch row discards that row and all younger rows. The row before it becomes the youngest, and reads return its contents.
- R6: A resolve with `res_ok`=1 on a busy branch row marks that row confirmed. `retire` frees the oldest row only when the row after it is confirmed; otherwise `retire` has no effect.
- R7: Rows are claimed in ring order. After row `NROW-1` the next row claimed is row 0.
- R8: A resolve whose tag is not a busy branch row has no effect. This covers the oldest row and any tag of `NROW` or more.
- R9: When a `br_enter` and an in-range `res_ok`=0 resolve arrive in the same cycle, the resolve takes effect and the enter is dropped.
- R10: `retire` has no effect when only one row is busy, and none in a cycle with an in-range `res_ok`=0 resolve.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the youngest row |
| wr_addr | input | AW | Register written |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Register read |
| rd_data | output | DW | Read data from the youngest row |
| br_enter | input | 1 | Request to open a branch row |
| br_tag | output | RW | Row the next accepted enter claims |
| br_full | output | 1 | All rows busy |
| res_valid | input | 1 | Branch resolve strobe |
| res_ok | input | 1 | 1 = prediction correct, 0 = wrong |
| res_tag | input | RW | Row of the resolved branch |
| retire | input | 1 | Request to free the oldest row |

## Verification
Most errors in the ring pointers show up at the ports within one cycle. A tail pointer that is off by one row changes `br_tag`, and reads then return a neighbour's data. A wrong busy count shows up as `br_full` being asserted too early or too late after a known number of enters. A retire or resolve that is wrongly accepted or wrongly refused leaves no immediate trace. The bench therefore exposes it a few cycles later by filling the ring and checking exactly when `br_full` rises, and by reading register values after a rollback.

// File: rtl/spec_ckpt_regfile.sv
module spec_ckpt_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int NROW = 5,
  localparam int AW  = $clog2(NREG),
  localparam int RW  = $clog2(NROW),
  localparam int CW  = $clog2(NROW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          br_enter,
  output logic [RW-1:0] br_tag,
  output logic          br_full,
  input  logic          res_valid,
  input  logic          res_ok,
  input  logic [RW-1:0] res_tag,
  input  logic          retire
);

  logic [DW-1:0]   mem [NROW][NREG];
  logic [RW-1:0]   head, tail;
  logic [CW-1:0]   count;
  logic [NROW-1:0] conf;

  function automatic logic [RW-1:0] nxt(input logic [RW-1:0] x);
    return (x == RW'(NROW - 1)) ? '0 : x + 1'b1;
  endfunction

  function automatic logic [RW-1:0] prv(input logic [RW-1:0] x);
    return (x == '0) ? RW'(NROW - 1) : x - 1'b1;
  endfunction

  logic [RW-1:0] off;
  logic          in_rng, miss, hit, enter_ok, ret_ok;

  assign off      = (res_tag >= head) ? res_tag - head : res_tag + RW'(NROW) - head;
  assign in_rng   = (int'(res_tag) < NROW) && (off != '0) && (CW'(off) < count);
  assign miss     = res_valid && !res_ok && in_rng;
  assign hit      = res_valid &&  res_ok && in_rng;
  assign br_full  = (count == CW'(NROW));
  assign br_tag   = nxt(tail);
  assign enter_ok = br_enter && !br_full && !miss;
  assign ret_ok   = retire && !miss && (count > CW'(1)) && conf[nxt(head)];
  assign rd_data  = mem[tail][rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NROW; r++)
        for (int c = 0; c < NREG; c++)
          mem[r][c] <= '0;
      head  <= '0;
      tail  <= '0;
      count <= CW'(1);
      conf  <= '0;
    end else begin
      if (wr_en) mem[tail][wr_addr] <= wr_data;
      if (enter_ok) begin
        for (int c = 0; c < NREG; c++)
          mem[nxt(tail)][c] <= (wr_en && wr_addr == AW'(c)) ? wr_data : mem[tail][c];
        conf[nxt(tail)] <= 1'b0;
        tail <= nxt(tail);
      end
      if (miss) tail <= prv(res_tag);
      if (hit)  conf[res_tag] <= 1'b1;
      if (ret_ok) head <= nxt(head);
      if (miss) count <= CW'(off);
      else      count <= count + CW'(enter_ok) - CW'(ret_ok);
    end
  end

endmodule

module spec_ckpt_regfile_chk #(
  parameter int NROW = 5,
  localparam int RW  = $clog2(NROW),
  localparam int CW  = $clog2(NROW + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          br_enter,
  input logic          br_full,
  input logic [RW-1:0] br_tag,
  input logic          res_valid,
  input logic          res_ok,
  input logic [RW-1:0] head,
  input logic [RW-1:0] tail,
  input logic [CW-1:0] count
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (head == '0 && tail == '0 && count == CW'(1)));

  assert_enter_claims_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_enter && !br_full && !(res_valid && !res_ok)) |=> (tail == $past(br_tag)));

  assert_full_refuses_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_enter && br_full && !(res_valid && !res_ok)) |=> $stable(tail));

  assert_count_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= CW'(1)) && (int'(count) <= NROW));

  assert_ring_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tail) == (int'(head) + int'(count) - 1) % NROW);

endmodule

bind spec_ckpt_regfile spec_ckpt_regfile_chk #(.NROW(NROW)) i_chk (
  .clk(clk), .rst_n(rst_n), .br_enter(br_enter), .br_full(br_full),
  .br_tag(br_tag), .res_valid(res_valid), .res_ok(res_ok),
  .head(head), .tail(tail), .count(count)
);

// File: tb/test_spec_ckpt_regfile.sv
module test_spec_ckpt_regfile;
  localparam int NREG = 8, DW = 16, NROW = 5, AW = 3, RW = 3;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, br_enter = 0, res_valid = 0, res_ok = 0, retire = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [DW-1:0] wr_data = 0, rd_data, e;
  logic [RW-1:0] br_tag, res_tag = 0;
  logic br_full;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spec_ckpt_regfile #(.NREG(NREG), .DW(DW), .NROW(NROW)) i_spec_ckpt_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .br_enter(br_enter), .br_tag(br_tag),
    .br_full(br_full), .res_valid(res_valid), .res_ok(res_ok), .res_tag(res_tag),
    .retire(retire));

  localparam logic [38:0] VEC [6] = '{
    {1'b1, 3'd1, 16'h1111, 3'd1, 16'h1111},
    {1'b1, 3'd2, 16'h2222, 3'd1, 16'h1111},
    {1'b1, 3'd7, 16'hA7A7, 3'd2, 16'h2222},
    {1'b0, 3'd0, 16'h0000, 3'd7, 16'hA7A7},
    {1'b1, 3'd1, 16'h1234, 3'd1, 16'h1234},
    {1'b0, 3'd0, 16'h0000, 3'd0, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    wr_en = 0; br_enter = 0; res_valid = 0; retire = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic enter(); br_enter = 1; tick(); endtask

  task automatic resolve(input logic [RW-1:0] t, input logic ok);
    res_valid = 1; res_tag = t; res_ok = ok; tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 full", br_full, 0);
    chk("R1 tag", br_tag, 1);
    rd(0, 0, "R1 r0"); rd(7, 0, "R1 r7");
    // R2 vector table on row 0
    for (int i = 0; i < 6; i++) begin
      {wr_en, wr_addr, wr_data, rd_addr, e} = VEC[i];
      tick();
      rd(rd_addr, e, "R2 table");
    end
    // R3 enter with same-cycle write
    wr_en = 1; wr_addr = 3; wr_data = 16'h3333; br_enter = 1; tick();
    rd(3, 16'h3333, "R3 merged copy");
    rd(1, 16'h1234, "R3 copy");
    chk("R3 tag", br_tag, 2);
    wr_en = 1; wr_addr = 1; wr_data = 16'hBEEF; tick();
    rd(1, 16'hBEEF, "R3 write new row");
    enter(); enter(); enter();
    chk("R4 full", br_full, 1);
    chk("R7 wrap tag", br_tag, 0);
    enter();
    chk("R4 refused tag", br_tag, 0);
    chk("R4 refused full", br_full, 1);
    // R8 ignored resolves
    resolve(0, 0);
    chk("R8 oldest tag", br_full, 1);
    resolve(6, 0);
    chk("R8 tag beyond", br_full, 1);
    rd(1, 16'hBEEF, "R8 data");
    // R9 mispredict beats enter
    br_enter = 1; resolve(3, 0);
    chk("R9 tag", br_tag, 3);
    chk("R5 full", br_full, 0);
    rd(1, 16'hBEEF, "R5 row2");
    resolve(1, 0);
    rd(1, 16'h1234, "R5 back to row0");
    rd(3, 16'h3333, "R5 row0 r3");
    chk("R5 tag", br_tag, 1);
    // R10 retire with one row
    retire = 1; tick();
    chk("R10 single row", br_tag, 1);
    // R6 confirm and retire
    enter();
    resolve(1, 1);
    retire = 1; tick();
    rd(1, 16'h1234, "R6 after retire");
    chk("R6 tag", br_tag, 2);
    enter();
    retire = 1; tick();
    enter(); enter();
    chk("R6 unconfirmed retire ignored", br_full, 0);
    enter();
    chk("R6 full after fill", br_full, 1);
    chk("R7 wrap tag", br_tag, 1);
    wr_en = 1; wr_addr = 6; wr_data = 16'h0660; tick();
    rd(6, 16'h0660, "R7 row0 write");
    // R10 retire with mispredict
    resolve(2, 1);
    retire = 1; resolve(3, 0);
    enter(); enter();
    chk("R10 not yet full", br_full, 0);
    enter();
    chk("R10 retire dropped", br_full, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule